// File: doc/BRIEF.md
# Packetized SPI Block Write Engine

This block moves one block of payload bytes toward an SPI slave once the host has already issued and had accepted the block-write command. It cuts the payload into packets whose size is a power of two and puts a one-byte order header in front of each packet. When checksum protection is on, a 16-bit CRC goes after each packet's payload. Payload arrives on a byte stream with valid/ready handshaking. Every outgoing byte leaves through a write port with valid/ready handshaking toward the SPI master.

The engine sends all packets back to back and does not wait for an acknowledgement per packet. After the final packet it requests four response bytes from the master. The slave may still be returning the acknowledgement of an earlier packet at that point, so the engine takes the latest response-start byte in the window as the one for the final packet and judges that byte. The transfer finishes with a single-cycle done pulse and an error flag.

Top module: `spi_blkwr_engine`

## Requirements
- R1: A start whose length is 4 or less ends at once with done and error. No byte is written and no response byte is requested.
- R2: A start whose packet-size exponent lies outside the range LOG_MIN to LOG_MAX ends at once with done and error. No byte is written.
- R3: Each packet opens with header byte 0xF0 OR an order code in bits 1:0. The code is 1 for the first of several packets, 2 for an inner packet, and 3 for the final packet or the only packet.
- R4: Every packet except the last carries exactly 2^exponent payload bytes. The last packet carries the remainder, and the payload bytes leave in arrival order.
- R5: With CRC enabled, two bytes follow each packet's payload, high byte first. They are the CRC-CCITT (polynomial 0x1021, MSB first, no final XOR) of that packet's payload. With CRC disabled no such bytes appear.
- R6: The CRC starts again from seed 0xFFFF at every packet, so no packet's CRC depends on an earlier packet.
- R7: The input stream is accepted only in payload slots. in_ready stays low during header and CRC slots, and a payload byte is taken in the same cycle that it is written.
- R8: After the final packet, including its CRC, the engine requests exactly four response bytes, and only then.
- R9: In the response window (byte 0 received first), the engine searches indices 2, 1, 0 in that order for a byte whose upper nibble is 0xC and takes the first one it finds. The transfer succeeds only if that byte's lower nibble is 3 and the byte after it is 0x00. If no such byte exists, or if either condition fails, error is raised.
- R10: done is a one-cycle pulse. error is valid with done and holds until the next start.
- R11: A written byte held back by wr_ready low keeps the same value until it is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Begin a transfer (taken only when idle) |
| len_i | input | LEN_W | Total payload length in bytes |
| log_i | input | LOG_W | log2 of the packet size |
| crc_en_i | input | 1 | Append a CRC16 to each packet |
| in_data_i | input | 8 | Payload byte |
| in_valid_i | input | 1 | Payload byte valid |
| in_ready_o | output | 1 | Payload byte taken |
| wr_data_o | output | 8 | Byte toward the SPI master |
| wr_valid_o | output | 1 | wr_data_o valid |
| wr_ready_i | input | 1 | SPI master accepts the byte |
| rd_req_o | output | 1 | Requesting a response byte |
| rd_valid_i | input | 1 | Response byte present |
| rd_data_i | input | 8 | Response byte |
| done_o | output | 1 | Transfer finished (one-cycle pulse) |
| err_o | output | 1 | Transfer failed or was rejected |

## Verification
The bench builds the engine with LEN_W=10, LOG_MIN=2 and LOG_MAX=4, so packets hold 4, 8 or 16 bytes. This lets it sweep every length from 5 to 40 against every packet size, with CRC on and off. That sweep covers single packets, exact multiples of the packet size, short final packets and long inner runs, all under random back-pressure on both streams. A second sweep tries all 256 response windows built from four byte values, so every position and every mix of valid, malformed and missing acknowledgements in the backward search is exercised. Rejected lengths and out-of-range exponents are also covered.

// File: rtl/blkwr_pkg.sv
// Shared definitions for the packetized block write engine.
package blkwr_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_HDR,
        ST_DATA,
        ST_CRCH,
        ST_CRCL,
        ST_RESP,
        ST_CHECK
    } seq_st_e;

    localparam logic [3:0]  HDR_NIB    = 4'hF;
    localparam logic [3:0]  ACK_NIB    = 4'hC;
    localparam logic [3:0]  ACK_LAST   = 4'h3;
    localparam logic [1:0]  ORD_FIRST  = 2'd1;
    localparam logic [1:0]  ORD_INNER  = 2'd2;
    localparam logic [1:0]  ORD_LAST   = 2'd3;
    localparam logic [15:0] CRC_SEED   = 16'hFFFF;
    localparam logic [15:0] CRC_POLY   = 16'h1021;
    localparam int          RESP_BYTES = 4;
    localparam int          MIN_LEN    = 5;

endpackage

// File: rtl/blkwr_crc16.sv
// Bytewise CRC-CCITT accumulator.
// Folds one byte per cycle into the register when upd is high.
// clr reloads the seed and takes priority over upd.
// Assumes clr and upd never come in the same cycle.
module blkwr_crc16
    import blkwr_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        clr,
    input  logic        upd,
    input  logic [7:0]  din,
    output logic [15:0] crc_o
);

    logic [15:0]      crc_q;
    logic [8:0][15:0] stage;

    assign stage[0] = crc_q ^ {din, 8'h00};

    // One shift/xor step per input bit, MSB first.
    for (genvar b = 0; b < 8; b++) begin : g_bit
        assign stage[b+1] = stage[b][15] ? ((stage[b] << 1) ^ CRC_POLY)
                                         : (stage[b] << 1);
    end

    // Hold or advance the running remainder.
    always_ff @(posedge clk) begin
        if (!rst_n)   crc_q <= CRC_SEED;
        else if (clr) crc_q <= CRC_SEED;
        else if (upd) crc_q <= stage[8];
    end

    assign crc_o = crc_q;

    // R6: every packet starts from the seed.
    a_r6_seed_after_clr: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (crc_o == CRC_SEED));

endmodule

// File: rtl/blkwr_ack_scan.sv
// Response window judge.
// win_i holds WIN bytes, with byte 0 (the first received) in the low bits.
// The judge takes the highest index from WIN-2 down to 0 whose upper nibble
// marks a response start. That byte must report a final packet and be
// followed by a zero status byte. Purely combinational.
module blkwr_ack_scan
    import blkwr_pkg::*;
#(
    parameter int WIN = RESP_BYTES
) (
    input  logic [WIN*8-1:0] win_i,
    output logic             ok_o
);

    // Ascending scan: the last match wins, which equals a backward search.
    always_comb begin
        ok_o = 1'b0;
        for (int k = 0; k <= WIN - 2; k++) begin
            if (win_i[k*8+4 +: 4] == ACK_NIB)
                ok_o = (win_i[k*8 +: 4] == ACK_LAST) &&
                       (win_i[(k+1)*8 +: 8] == 8'h00);
        end
    end

endmodule

// File: rtl/blkwr_pktseq.sv
// Packet sequencer for the block write engine.
// It validates the request, cuts the payload into packets and emits each
// packet's header, payload and optional CRC. It then collects the response
// window and reports the verdict.
// Assumes LOG_MAX < LEN_W and a command phase that has already completed.
module blkwr_pktseq
    import blkwr_pkg::*;
#(
    parameter int LEN_W   = 16,
    parameter int LOG_MIN = 8,
    parameter int LOG_MAX = 13,
    parameter int LOG_W   = $clog2(LOG_MAX + 1)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  start_i,
    input  logic [LEN_W-1:0]      len_i,
    input  logic [LOG_W-1:0]      log_i,
    input  logic                  crc_en_i,
    input  logic [7:0]            in_data_i,
    input  logic                  in_valid_i,
    output logic                  in_ready_o,
    output logic [7:0]            wr_data_o,
    output logic                  wr_valid_o,
    input  logic                  wr_ready_i,
    output logic                  rd_req_o,
    input  logic                  rd_valid_i,
    input  logic [7:0]            rd_data_i,
    input  logic [15:0]           crc_i,
    output logic                  crc_clr_o,
    output logic                  crc_upd_o,
    output logic [RESP_BYTES*8-1:0] win_o,
    input  logic                  ack_ok_i,
    output logic                  done_o,
    output logic                  err_o
);

    localparam int RIDX_W = $clog2(RESP_BYTES);

    seq_st_e                 st_q;
    logic [LEN_W-1:0]        rem_q;
    logic [LEN_W-1:0]        nleft_q;
    logic [LEN_W-1:0]        psize_q;
    logic                    first_q;
    logic                    last_q;
    logic                    crc_en_q;
    logic [RIDX_W-1:0]       ridx_q;
    logic [RESP_BYTES*8-1:0] win_q;
    logic                    done_q;
    logic                    err_q;

    logic                    last_now;
    logic [1:0]              ord;
    logic                    wr_hs;
    logic                    bad_req;

    // Packet classification for the header slot.
    always_comb begin
        last_now = (rem_q <= psize_q);
        if (last_now)     ord = ORD_LAST;
        else if (first_q) ord = ORD_FIRST;
        else              ord = ORD_INNER;
    end

    assign bad_req = (len_i < LEN_W'(MIN_LEN)) ||
                     (log_i < LOG_W'(LOG_MIN)) || (log_i > LOG_W'(LOG_MAX));

    // Output byte mux and valid per slot.
    always_comb begin
        wr_data_o  = 8'h00;
        wr_valid_o = 1'b0;
        unique case (st_q)
            ST_HDR:  begin wr_data_o = {HDR_NIB, 2'b00, ord}; wr_valid_o = 1'b1; end
            ST_DATA: begin wr_data_o = in_data_i;             wr_valid_o = in_valid_i; end
            ST_CRCH: begin wr_data_o = crc_i[15:8];           wr_valid_o = 1'b1; end
            ST_CRCL: begin wr_data_o = crc_i[7:0];            wr_valid_o = 1'b1; end
            default: ;
        endcase
    end

    assign wr_hs      = wr_valid_o && wr_ready_i;
    assign in_ready_o = (st_q == ST_DATA) && wr_ready_i;
    assign crc_clr_o  = (st_q == ST_HDR) && wr_hs;
    assign crc_upd_o  = (st_q == ST_DATA) && wr_hs;
    assign rd_req_o   = (st_q == ST_RESP);
    assign win_o      = win_q;
    assign done_o     = done_q;
    assign err_o      = err_q;

    // Sequencer state, counters and verdict.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q     <= ST_IDLE;
            rem_q    <= '0;
            nleft_q  <= '0;
            psize_q  <= '0;
            first_q  <= 1'b0;
            last_q   <= 1'b0;
            crc_en_q <= 1'b0;
            ridx_q   <= '0;
            win_q    <= '0;
            done_q   <= 1'b0;
            err_q    <= 1'b0;
        end else begin
            done_q <= 1'b0;
            unique case (st_q)
                ST_IDLE: if (start_i) begin
                    crc_en_q <= crc_en_i;
                    ridx_q   <= '0;
                    if (bad_req) begin
                        done_q <= 1'b1;
                        err_q  <= 1'b1;
                    end else begin
                        err_q   <= 1'b0;
                        rem_q   <= len_i;
                        psize_q <= LEN_W'(1) << log_i;
                        first_q <= 1'b1;
                        st_q    <= ST_HDR;
                    end
                end
                ST_HDR: if (wr_hs) begin
                    nleft_q <= last_now ? rem_q : psize_q;
                    last_q  <= last_now;
                    st_q    <= ST_DATA;
                end
                ST_DATA: if (wr_hs) begin
                    nleft_q <= nleft_q - LEN_W'(1);
                    rem_q   <= rem_q - LEN_W'(1);
                    if (nleft_q == LEN_W'(1)) begin
                        first_q <= 1'b0;
                        if (crc_en_q)    st_q <= ST_CRCH;
                        else if (last_q) st_q <= ST_RESP;
                        else             st_q <= ST_HDR;
                    end
                end
                ST_CRCH: if (wr_hs) st_q <= ST_CRCL;
                ST_CRCL: if (wr_hs) st_q <= last_q ? ST_RESP : ST_HDR;
                ST_RESP: if (rd_valid_i) begin
                    win_q[{ridx_q, 3'b000} +: 8] <= rd_data_i;
                    ridx_q <= ridx_q + RIDX_W'(1);
                    if (ridx_q == RIDX_W'(RESP_BYTES - 1)) st_q <= ST_CHECK;
                end
                ST_CHECK: begin
                    done_q <= 1'b1;
                    err_q  <= !ack_ok_i;
                    st_q   <= ST_IDLE;
                end
                default: st_q <= ST_IDLE;
            endcase
        end
    end

    // R1: a short block is refused on the next cycle.
    a_r1_short_reject: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && st_q == ST_IDLE && len_i < LEN_W'(MIN_LEN)) |=> (done_o && err_o));
    // R4: no payload byte is taken beyond the packet or the block.
    a_r4_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_DATA && wr_hs) |-> (nleft_q != '0 && rem_q != '0));
    // R7: input is accepted only as a byte that is written at once.
    a_r7_in_passthru: assert property (@(posedge clk) disable iff (!rst_n)
        in_ready_o |-> (wr_ready_i && wr_data_o == in_data_i));
    // R8: the response is read only after all payload has left.
    a_r8_rd_after_data: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req_o |-> (rem_q == '0));
    // R10: done lasts a single cycle.
    a_r10_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);
    // R11: a stalled header or CRC byte stays put.
    a_r11_hold_byte: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid_o && !wr_ready_i && st_q != ST_DATA) |=> (wr_valid_o && $stable(wr_data_o)));

endmodule

// File: rtl/spi_blkwr_engine.sv
// Packetized SPI block write engine, top level.
// Joins the packet sequencer, the CRC accumulator and the response judge.
// Assumes the block-write command has already been accepted by the slave.
module spi_blkwr_engine
    import blkwr_pkg::*;
#(
    parameter int LEN_W   = 16,
    parameter int LOG_MIN = 8,
    parameter int LOG_MAX = 13,
    parameter int LOG_W   = $clog2(LOG_MAX + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [LEN_W-1:0] len_i,
    input  logic [LOG_W-1:0] log_i,
    input  logic             crc_en_i,
    input  logic [7:0]       in_data_i,
    input  logic             in_valid_i,
    output logic             in_ready_o,
    output logic [7:0]       wr_data_o,
    output logic             wr_valid_o,
    input  logic             wr_ready_i,
    output logic             rd_req_o,
    input  logic             rd_valid_i,
    input  logic [7:0]       rd_data_i,
    output logic             done_o,
    output logic             err_o
);

    logic [15:0]             crc;
    logic                    crc_clr;
    logic                    crc_upd;
    logic [RESP_BYTES*8-1:0] win;
    logic                    ack_ok;

    blkwr_pktseq #(
        .LEN_W(LEN_W), .LOG_MIN(LOG_MIN), .LOG_MAX(LOG_MAX), .LOG_W(LOG_W)
    ) u_seq (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .len_i(len_i),
        .log_i(log_i), .crc_en_i(crc_en_i), .in_data_i(in_data_i),
        .in_valid_i(in_valid_i), .in_ready_o(in_ready_o), .wr_data_o(wr_data_o),
        .wr_valid_o(wr_valid_o), .wr_ready_i(wr_ready_i), .rd_req_o(rd_req_o),
        .rd_valid_i(rd_valid_i), .rd_data_i(rd_data_i), .crc_i(crc),
        .crc_clr_o(crc_clr), .crc_upd_o(crc_upd), .win_o(win),
        .ack_ok_i(ack_ok), .done_o(done_o), .err_o(err_o)
    );

    blkwr_crc16 u_crc (
        .clk(clk), .rst_n(rst_n), .clr(crc_clr), .upd(crc_upd),
        .din(wr_data_o), .crc_o(crc)
    );

    blkwr_ack_scan #(.WIN(RESP_BYTES)) u_ack (
        .win_i(win), .ok_o(ack_ok)
    );

endmodule

// File: tb/test_spi_blkwr_engine.sv
module test_spi_blkwr_engine;

    localparam int LEN_W = 10, LOG_MIN = 2, LOG_MAX = 4, LOG_W = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic [LEN_W-1:0] len = '0;
    logic [LOG_W-1:0] lg = '0;
    logic crc_en = 1'b0;
    logic [7:0] in_data;
    logic in_valid = 1'b0, in_ready;
    logic [7:0] wr_data;
    logic wr_valid, wr_ready = 1'b0;
    logic rd_req, rd_valid = 1'b0;
    logic [7:0] rd_data;
    logic done, err;

    always #5 clk = ~clk;

    spi_blkwr_engine #(.LEN_W(LEN_W), .LOG_MIN(LOG_MIN), .LOG_MAX(LOG_MAX), .LOG_W(LOG_W))
    i_spi_blkwr_engine (
        .clk(clk), .rst_n(rst_n), .start_i(start), .len_i(len), .log_i(lg),
        .crc_en_i(crc_en), .in_data_i(in_data), .in_valid_i(in_valid),
        .in_ready_o(in_ready), .wr_data_o(wr_data), .wr_valid_o(wr_valid),
        .wr_ready_i(wr_ready), .rd_req_o(rd_req), .rd_valid_i(rd_valid),
        .rd_data_i(rd_data), .done_o(done), .err_o(err)
    );

    function automatic logic [7:0] pat(input int seed, input int k);
        return 8'((seed * 37) + (k * 13) + (k >> 3));
    endfunction

    function automatic logic [15:0] crc_step(input logic [15:0] c, input logic [7:0] b);
        logic [15:0] r = c ^ {b, 8'h00};
        for (int i = 0; i < 8; i++) r = r[15] ? ((r << 1) ^ 16'h1021) : (r << 1);
        return r;
    endfunction

    // Expected verdict from the requirement: backward search over indices 2..0.
    function automatic bit ack_good(input logic [31:0] w);
        for (int i = 2; i >= 0; i--)
            if (w[i*8+4 +: 4] == 4'hC) return (w[i*8 +: 4] == 4'h3) && (w[(i+1)*8 +: 8] == 8'h00);
        return 1'b0;
    endfunction

    int seed = 0;
    int src_idx = 0, rd_idx = 0;
    logic clr = 1'b0;
    logic [31:0] win = '0;
    assign in_data = pat(seed, src_idx);
    assign rd_data = win[rd_idx*8 +: 8];

    // sampler state
    logic [7:0] cap [0:255];
    int cap_n = 0, in_hs_n = 0, stall_n = 0, rd_n = 0;
    bit in_hs_q = 0, rd_hs_q = 0, done_seen = 0, err_seen = 0;
    bit pv = 0, pr = 0, pdone = 0;
    logic [7:0] pd = '0;
    int s_chk = 0, s_fail = 0, n_chk = 0, n_fail = 0;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Driver: back-pressure and response bytes, changed just after each edge.
    initial begin
        logic [15:0] lf = 16'hACE1;
        forever begin
            @(posedge clk); #2;
            if (clr) begin src_idx = 0; rd_idx = 0; end
            else begin
                if (in_hs_q) src_idx++;
                if (rd_hs_q) rd_idx++;
            end
            lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
            wr_ready = lf[0] | lf[3];
            in_valid = lf[5] | lf[7];
            rd_valid = rd_req && lf[9];
        end
    end

    // Sampler at the falling edge.
    initial begin
        forever begin
            @(negedge clk);
            if (clr) begin
                cap_n = 0; in_hs_n = 0; stall_n = 0; rd_n = 0; done_seen = 0;
                in_hs_q = 0; rd_hs_q = 0;
            end else begin
                if (pv && !pr && wr_valid) begin
                    s_chk++;
                    if (wr_data !== pd) begin
                        s_fail++;
                        $display("FAIL R11 held byte actual=%0h expected=%0h", wr_data, pd);
                    end
                end
                if (wr_valid && wr_ready) begin
                    cap[cap_n[7:0]] = wr_data; cap_n++;
                    if (!in_ready) stall_n++;
                end
                in_hs_q = in_valid && in_ready;
                if (in_hs_q) in_hs_n++;
                rd_hs_q = rd_req && rd_valid;
                if (rd_hs_q) rd_n++;
                if (done) begin
                    done_seen = 1; err_seen = err;
                    s_chk++;
                    if (pdone) begin
                        s_fail++;
                        $display("FAIL R10 done wider than one cycle actual=1 expected=0");
                    end
                end
            end
            pv = wr_valid; pr = wr_ready; pd = wr_data; pdone = done;
        end
    end

    logic [7:0] exp_b [0:255];
    int exp_k [0:255];
    int exp_n;

    task automatic build_exp(input int ln, input int lgv, input bit ce);
        int rem = ln, idx = 0, psz = 1 << lgv;
        bit first = 1;
        exp_n = 0;
        while (rem > 0) begin
            int nb = (rem <= psz) ? rem : psz;
            logic [1:0] ord = (rem <= psz) ? 2'd3 : (first ? 2'd1 : 2'd2);
            logic [15:0] c = 16'hFFFF;
            exp_b[exp_n] = {6'b111100, ord}; exp_k[exp_n] = 0; exp_n++;
            for (int k = 0; k < nb; k++) begin
                exp_b[exp_n] = pat(seed, idx); exp_k[exp_n] = 1; exp_n++;
                c = crc_step(c, pat(seed, idx)); idx++;
            end
            if (ce) begin
                exp_b[exp_n] = c[15:8]; exp_k[exp_n] = 2; exp_n++;
                exp_b[exp_n] = c[7:0];  exp_k[exp_n] = 2; exp_n++;
            end
            rem -= nb; first = 0;
        end
    endtask

    task automatic run_xfer(input int ln, input int lgv, input bit ce, input logic [31:0] w);
        int wd = 0;
        @(posedge clk); #1;
        clr = 1; len = LEN_W'(ln); lg = LOG_W'(lgv); crc_en = ce; win = w;
        @(posedge clk); #1;
        clr = 0; start = 1;
        @(posedge clk); #1;
        start = 0;
        while (!done_seen && wd < 3000) begin @(posedge clk); wd++; end
        #1;
        chk(done_seen, "R10 watchdog: done never arrived", 0, 1);
    endtask

    initial begin
        logic [7:0] vals [0:3];
        logic [31:0] good_w;
        vals[0] = 8'h00; vals[1] = 8'hC3; vals[2] = 8'hC1; vals[3] = 8'hF3;
        // window: byte0=C2 (earlier ack) 00, byte2=C3 00 -> pass
        good_w = {8'h00, 8'hC3, 8'h00, 8'hC2};

        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(!done && !wr_valid && !in_ready && !rd_req, "R10 reset state idle",
            {done, wr_valid, in_ready, rd_req}, 0);
        @(posedge clk); #1; rst_n = 1;

        // R1: short lengths rejected
        for (int l = 0; l <= 4; l++) begin
            run_xfer(l, 3, 1'b1, good_w);
            chk(err_seen, "R1 short length error", err_seen, 1);
            chk(cap_n == 0 && rd_n == 0, "R1 nothing written or read", cap_n + rd_n, 0);
        end
        // R2: exponent out of range
        run_xfer(20, 1, 1'b0, good_w);
        chk(err_seen && cap_n == 0, "R2 exponent below range", cap_n, 0);
        run_xfer(20, 5, 1'b1, good_w);
        chk(err_seen && cap_n == 0, "R2 exponent above range", cap_n, 0);

        // Stream sweep: R3 R4 R5 R6 R7 R8
        for (int ce = 0; ce < 2; ce++) begin
            for (int lgv = LOG_MIN; lgv <= LOG_MAX; lgv++) begin
                for (int l = 5; l <= 40; l++) begin
                    seed++;
                    build_exp(l, lgv, ce[0]);
                    run_xfer(l, lgv, ce[0], good_w);
                    chk(!err_seen, "R9 good window accepted", err_seen, 0);
                    chk(cap_n == exp_n, "R4 byte count", cap_n, exp_n);
                    for (int i = 0; i < exp_n && i < cap_n; i++) begin
                        if (exp_k[i] == 0)      chk(cap[i] == exp_b[i], "R3 header byte", cap[i], exp_b[i]);
                        else if (exp_k[i] == 1) chk(cap[i] == exp_b[i], "R4 payload byte", cap[i], exp_b[i]);
                        else                    chk(cap[i] == exp_b[i], "R5 R6 crc byte", cap[i], exp_b[i]);
                    end
                    chk(in_hs_n == l, "R7 input bytes taken", in_hs_n, l);
                    chk(stall_n == exp_n - l, "R7 header/crc slots stall input", stall_n, exp_n - l);
                    chk(rd_n == 4, "R8 response reads", rd_n, 4);
                end
            end
        end

        // Response window sweep: R9
        for (int a = 0; a < 4; a++)
            for (int b = 0; b < 4; b++)
                for (int c = 0; c < 4; c++)
                    for (int d = 0; d < 4; d++) begin
                        logic [31:0] w = {vals[d], vals[c], vals[b], vals[a]};
                        seed++;
                        run_xfer(6, 2, 1'b0, w);
                        chk(err_seen == !ack_good(w), "R9 response verdict", err_seen, !ack_good(w));
                        chk(rd_n == 4, "R8 response reads", rd_n, 4);
                    end

        $display("[TB] %0d tests run, %0d failed", n_chk + s_chk, n_fail + s_fail);
        $finish;
    end

endmodule